// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of page-table entries. A lookup presents a virtual page number together with the identifier of the running process. Every stored entry is compared against that pair at the same time. When a valid entry agrees on both fields, the block reports a hit and returns the entry's physical frame number and dirty flag in the same cycle. Otherwise it reports a miss.

After a miss, an external page-table walker resolves the mapping and writes it back through the fill port. Each entry stores the process identifier it belongs to, so mappings for several processes can be held at once. A context switch therefore does not force the buffer to be emptied. A single-cycle flush is still available to discard every entry.

A fill goes to one slot, chosen in this order of preference:
- the slot that already holds the same page and process;
- otherwise, the lowest-numbered empty slot;
- otherwise, the slot named by a binary-tree pseudo-LRU structure, which a hit or a fill updates to mark the slot as recently used.

Top module: `proc_tlb`

## Requirements
- R1: After reset, every entry is invalid, so any lookup reports a miss.
- R2: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high, in the same cycle as the request. While `lk_valid` is low, both are low.
- R3: `lk_hit` is high only when a valid entry holds both the requested page number and the requested process identifier. On a hit, `lk_pfn` and `lk_dirty` carry that entry's stored values. When there is no hit, both are zero.
- R4: Two entries with the same page number but different process identifiers coexist. Each returns its own frame.
- R5: A fill whose page and process match a valid entry rewrites that entry in place. No duplicate is created.
- R6: Otherwise, a fill that finds at least one invalid entry writes the lowest-numbered invalid entry.
- R7: Otherwise, a fill overwrites the tree pseudo-LRU victim. The tree is defined as follows:
  - Nodes are numbered 1..N-1 in heap order; node n has children 2n and 2n+1, and leaf N+e stands for entry e.
  - The victim is found by starting at the root and taking the right child where the node bit is 1 and the left child where it is 0.
  - Touching entry e sets every node on its path to point away from it.
  - A fill touches the entry it writes. A lookup hit touches the hit entry, unless a fill is written in the same cycle, in which case only the fill touches.
- R8: `flush` invalidates every entry and zeroes all tree bits in one cycle. A fill presented in the same cycle is discarded.
- R9: A fill becomes visible to lookups from the cycle after it is presented. A lookup in the fill cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 6 | Virtual page number to search |
| cur_pid | input | 8 | Identifier of the running process |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup found no mapping |
| lk_pfn | output | 6 | Frame number of the hit entry |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| fill_valid | input | 1 | Write a mapping from the walker |
| fill_vpn | input | 6 | Page number of the fill |
| fill_pid | input | 8 | Process identifier of the fill |
| fill_pfn | input | 6 | Frame number of the fill |
| fill_dirty | input | 1 | Dirty flag of the fill |
| flush | input | 1 | Invalidate all entries |

## Verification
Directed cases cover three situations:
- the same page held under two processes, which separates the process-tag compare from a page-only compare;
- a refill of a resident mapping, which separates in-place update from allocation;
- a fill presented together with a flush, which checks that the fill is discarded.

A fill sequence then fills all eight slots in order and forces evictions. Lookups across every page after each eviction expose which slot the replacement tree chose.

Constrained-random traffic follows. It draws pages from a narrow range and processes from three identifiers so that hits, refills and evictions all occur often, with occasional flushes. Every cycle is compared against a reference model kept in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // How an incoming fill is placed in the array
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_UPDATE = 2'd1,
        WR_FREE   = 2'd2,
        WR_EVICT  = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 8,
    parameter int VPN_W = 6,
    parameter int PID_W = 8,
    parameter int PFN_W = 6,
    localparam int IW   = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [VPN_W-1:0] wvpn,
    input  logic [PID_W-1:0] wpid,
    input  logic [PFN_W-1:0] wpfn,
    input  logic             wdirty,
    input  logic [VPN_W-1:0] lvpn,
    input  logic [PID_W-1:0] lpid,
    input  logic [VPN_W-1:0] fvpn,
    input  logic [PID_W-1:0] fpid,
    output logic [N-1:0]     valid_vec,
    output logic [N-1:0]     lmatch,
    output logic [N-1:0]     fmatch,
    output logic [PFN_W-1:0] lpfn,
    output logic             ldirty
);

    logic [VPN_W-1:0] vpn_q   [N];
    logic [PID_W-1:0] pid_q   [N];
    logic [PFN_W-1:0] pfn_q   [N];
    logic             dirty_q [N];

    // One storage slot and its two comparators per entry
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                vpn_q[g]     <= '0;
                pid_q[g]     <= '0;
                pfn_q[g]     <= '0;
                dirty_q[g]   <= 1'b0;
            end else if (flush) begin
                valid_vec[g] <= 1'b0;
            end else if (we && (widx == IW'(g))) begin
                valid_vec[g] <= 1'b1;
                vpn_q[g]     <= wvpn;
                pid_q[g]     <= wpid;
                pfn_q[g]     <= wpfn;
                dirty_q[g]   <= wdirty;
            end
        end

        assign lmatch[g] = valid_vec[g] && (vpn_q[g] == lvpn) && (pid_q[g] == lpid);
        assign fmatch[g] = valid_vec[g] && (vpn_q[g] == fvpn) && (pid_q[g] == fpid);
    end

    // Read-out: OR of the matching slots, zero when none match
    always_comb begin
        lpfn   = '0;
        ldirty = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (lmatch[i]) begin
                lpfn   = lpfn | pfn_q[i];
                ldirty = ldirty | dirty_q[i];
            end
        end
    end

    AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lmatch)); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0)); // R8

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);

    logic [N-1:1] tree_q;
    logic [N-1:1] tree_nx;
    logic [IW:0]  tnode;
    logic [IW:0]  vnode;

    // Next tree: every node on the touched path points away from it
    always_comb begin
        tree_nx = tree_q;
        tnode   = (IW+1)'(N) + {1'b0, touch_idx};
        for (int l = 0; l < IW; l++) begin
            tree_nx[tnode[IW:1]] = ~tnode[0];
            tnode = tnode >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tree_q <= '0;
        end else if (clear) begin
            tree_q <= '0;
        end else if (touch_en) begin
            tree_q <= tree_nx;
        end
    end

    // Walk from the root following the node bits
    always_comb begin
        vnode = (IW+1)'(1);
        for (int l = 0; l < IW; l++) begin
            vnode = {vnode[IW-1:0], tree_q[vnode[IW-1:0]]};
        end
        victim = vnode[IW-1:0];
    end

    AST_TOUCH_AVOIDED: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !clear) |=> (victim != $past(touch_idx))); // R7

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [IW-1:0] plru_idx,
    output logic          any_free,
    output logic [IW-1:0] slot
);

    logic [IW-1:0] free_idx;

    // Lowest-numbered empty slot: scan downward so the lowest wins
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IW'(i);
            end
        end
    end

    assign any_free = ~&valid_vec;
    assign slot     = any_free ? free_idx : plru_idx;

endmodule

// File: rtl/proc_tlb.sv
module proc_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 6,
    parameter int PID_W   = 8,
    parameter int PFN_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] cur_pid,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_dirty,
    input  logic             flush
);
    import tlb_pkg::*;

    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lmatch;
    logic [ENTRIES-1:0] fmatch;
    logic [PFN_W-1:0]   raw_pfn;
    logic               raw_dirty;
    logic [IW-1:0]      hit_idx;
    logic [IW-1:0]      upd_idx;
    logic [IW-1:0]      plru_idx;
    logic [IW-1:0]      alloc_idx;
    logic               any_free;
    logic               any_hit;
    wr_kind_e           wr_kind;
    logic [IW-1:0]      wr_idx;
    logic               wr_en;
    logic               touch_en;
    logic [IW-1:0]      touch_idx;

    tlb_cam #(
        .N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .we        (wr_en),
        .widx      (wr_idx),
        .wvpn      (fill_vpn),
        .wpid      (fill_pid),
        .wpfn      (fill_pfn),
        .wdirty    (fill_dirty),
        .lvpn      (lk_vpn),
        .lpid      (cur_pid),
        .fvpn      (fill_vpn),
        .fpid      (fill_pid),
        .valid_vec (valid_vec),
        .lmatch    (lmatch),
        .fmatch    (fmatch),
        .lpfn      (raw_pfn),
        .ldirty    (raw_dirty)
    );

    // Encode the one-hot match vectors
    always_comb begin
        hit_idx = '0;
        upd_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lmatch[i]) hit_idx = hit_idx | IW'(i);
            if (fmatch[i]) upd_idx = upd_idx | IW'(i);
        end
    end

    assign any_hit = |lmatch;

    // Lookup result
    assign lk_hit   = lk_valid && any_hit;
    assign lk_miss  = lk_valid && !any_hit;
    assign lk_pfn   = lk_hit ? raw_pfn : '0;
    assign lk_dirty = lk_hit && raw_dirty;

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid_vec (valid_vec),
        .plru_idx  (plru_idx),
        .any_free  (any_free),
        .slot      (alloc_idx)
    );

    // Fill placement
    always_comb begin
        if (!fill_valid || flush)  wr_kind = WR_NONE;
        else if (|fmatch)          wr_kind = WR_UPDATE;
        else if (any_free)         wr_kind = WR_FREE;
        else                       wr_kind = WR_EVICT;
    end

    always_comb begin
        unique case (wr_kind)
            WR_NONE:   wr_idx = '0;
            WR_UPDATE: wr_idx = upd_idx;
            WR_FREE:   wr_idx = alloc_idx;
            WR_EVICT:  wr_idx = alloc_idx;
            default:   wr_idx = '0;
        endcase
    end

    assign wr_en = (wr_kind != WR_NONE);

    // Recency update: a fill takes precedence over a lookup hit
    assign touch_en  = wr_en || lk_hit;
    assign touch_idx = wr_en ? wr_idx : hit_idx;

    tlb_plru #(.N(ENTRIES)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (plru_idx)
    );

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss)); // R2

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WR_FREE) |-> !valid_vec[wr_idx]); // R6

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_vec[$past(wr_idx)]); // R9

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0 && !lk_dirty)); // R3

endmodule

// File: tb/proc_tlb_tb.sv
module proc_tlb_tb;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_valid = 1'b0;
    logic [5:0] lk_vpn = '0;
    logic [7:0] cur_pid = '0;
    logic       lk_hit, lk_miss, lk_dirty;
    logic [5:0] lk_pfn;
    logic       fill_valid = 1'b0;
    logic [5:0] fill_vpn = '0;
    logic [7:0] fill_pid = '0;
    logic [5:0] fill_pfn = '0;
    logic       fill_dirty = 1'b0;
    logic       flush = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    bit         m_v   [N];
    logic [5:0] m_vpn [N];
    logic [7:0] m_pid [N];
    logic [5:0] m_pfn [N];
    bit         m_d   [N];
    bit         m_t   [1:N-1];

    always #5 clk = ~clk;

    proc_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .cur_pid(cur_pid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_pfn(fill_pfn), .fill_dirty(fill_dirty), .flush(flush)
    );

    function automatic int find(input logic [5:0] vpn, input logic [7:0] pid);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
        return -1;
    endfunction

    function automatic int tree_victim();
        int n = 1;
        for (int l = 0; l < 3; l++) n = 2 * n + int'(m_t[n]);
        return n - N;
    endfunction

    task automatic touch(input int e);
        int n = N + e;
        for (int l = 0; l < 3; l++) begin
            m_t[n / 2] = (n % 2 == 0);
            n = n / 2;
        end
    endtask

    function automatic int place(input logic [5:0] vpn, input logic [7:0] pid);
        int k = find(vpn, pid);
        if (k >= 0) return k;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return tree_victim();
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        for (int i = 1; i < N; i++) m_t[i] = 1'b0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare combinational outputs, update model at posedge
    task automatic cyc(input string req, input bit lv, input logic [5:0] vpn, input logic [7:0] pid,
                       input bit fv, input logic [5:0] fvpn, input logic [7:0] fpid,
                       input logic [5:0] fpfn, input bit fd, input bit fl);
        int k;
        int w;
        @(negedge clk);
        lk_valid = lv; lk_vpn = vpn; cur_pid = pid;
        fill_valid = fv; fill_vpn = fvpn; fill_pid = fpid;
        fill_pfn = fpfn; fill_dirty = fd; flush = fl;
        #1;
        k = find(vpn, pid);
        check(req, "hit",   int'(lk_hit),   int'(lv && k >= 0));
        check(req, "miss",  int'(lk_miss),  int'(lv && k < 0));
        check(req, "pfn",   int'(lk_pfn),   (lv && k >= 0) ? int'(m_pfn[k]) : 0);
        check(req, "dirty", int'(lk_dirty), (lv && k >= 0) ? int'(m_d[k]) : 0);
        @(posedge clk);
        if (fl) begin
            model_clear();
        end else if (fv) begin
            w = place(fvpn, fpid);
            m_v[w] = 1'b1; m_vpn[w] = fvpn; m_pid[w] = fpid;
            m_pfn[w] = fpfn; m_d[w] = fd;
            touch(w);
        end else if (lv && k >= 0) begin
            touch(k);
        end
    endtask

    task automatic look(input string req, input logic [5:0] vpn, input logic [7:0] pid);
        cyc(req, 1'b1, vpn, pid, 1'b0, '0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic fill(input string req, input logic [5:0] vpn, input logic [7:0] pid,
                        input logic [5:0] pfn, input bit d);
        cyc(req, 1'b0, '0, '0, 1'b1, vpn, pid, pfn, d, 1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        look("R1", 6'd5, 8'd1);
        look("R1", 6'd0, 8'd0);

        // R9: fill not visible in its own cycle, visible after
        cyc("R9", 1'b1, 6'd5, 8'd1, 1'b1, 6'd5, 8'd1, 6'd9, 1'b1, 1'b0);
        look("R9", 6'd5, 8'd1);
        // R3: process tag must also match
        look("R3", 6'd5, 8'd2);
        look("R3", 6'd6, 8'd1);
        // R4: same page under a second process
        fill("R4", 6'd5, 8'd2, 6'd3, 1'b0);
        look("R4", 6'd5, 8'd2);
        look("R4", 6'd5, 8'd1);
        // R5: refill of a resident mapping updates in place
        fill("R5", 6'd5, 8'd1, 6'd20, 1'b0);
        look("R5", 6'd5, 8'd1);
        // R6: remaining slots fill in order
        for (int i = 0; i < 6; i++) fill("R6", 6'(10 + i), 8'd1, 6'(30 + i), i[0]);
        for (int i = 0; i < 6; i++) look("R6", 6'(10 + i), 8'd1);
        // R7: evictions chosen by the tree
        for (int j = 0; j < 4; j++) begin
            look("R7", 6'(10 + j), 8'd1);
            fill("R7", 6'(40 + j), 8'd3, 6'(50 + j), 1'b1);
            for (int i = 0; i < 6; i++) look("R7", 6'(10 + i), 8'd1);
            look("R7", 6'd5, 8'd1);
            look("R7", 6'd5, 8'd2);
            for (int i = 0; i <= j; i++) look("R7", 6'(40 + i), 8'd3);
        end
        // R8: flush with a simultaneous fill discards it
        cyc("R8", 1'b1, 6'd5, 8'd2, 1'b1, 6'd7, 8'd1, 6'd7, 1'b0, 1'b1);
        look("R8", 6'd7, 8'd1);
        look("R8", 6'd5, 8'd2);
        look("R8", 6'd40, 8'd3);
        fill("R8", 6'd8, 8'd1, 6'd1, 1'b0);
        look("R8", 6'd8, 8'd1);

        // R2 R3 R5 R7: constrained random traffic
        seed = 12345;
        void'($urandom(seed));
        for (int i = 0; i < 4000; i++) begin
            cyc("R2", 1'($urandom % 4 != 0), 6'($urandom % 14), 8'($urandom % 3),
                1'($urandom % 3 == 0), 6'($urandom % 14), 8'($urandom % 3),
                6'($urandom), 1'($urandom), 1'($urandom % 150 == 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule